// File: doc/BRIEF.md
# Two-Wire Programming Frame Transceiver

This block is the bit-level master of a clocked two-wire programming and debug link. It owns a clock line and a bidirectional data line. Bytes handed over on the user side leave as framed characters: a low start bit, eight data bits sent least significant bit first, an even parity bit and two high stop bits. For each bit period the master places the data bit on the line, holds the clock low for one half-period and then high for the other half. The target samples on the rising edge.

To receive, the master releases the data line and keeps pulsing the clock while it waits for the target's start bit. It samples the line at the end of each bit period. The hunt is bounded. Once the hunt ends, the master always clocks in the eight data bits, the parity bit and both stop bits, then reports the byte together with an error flag.

Two more sequences run on the same lines. The link-enable sequence is a fixed preamble that comes before normal traffic. The target-reset sequence holds the clock low for a set time after a lead-in. A higher-level sequencer issues all opcodes and decides when each sequence runs. Every timing value is a parameter counted in system clock cycles.

Top module: `twl_master`

## Requirements
- R1: A send emits 12 bit periods in this order: period 0 carries 0 (start); periods 1..8 carry send_byte bits 0..7; period 9 carries the XOR of the 8 data bits; periods 10 and 11 carry 1. Both drivers are on for the whole frame.
- R2: Every bit period of a send, receive or enable pulse train lasts 2*HALF_DIV cycles. Clock is low for the first HALF_DIV cycles and high for the last HALF_DIV cycles. Data out is constant across the period.
- R3: busy rises in the cycle after a request is accepted and falls exactly when the last period completes: 12 periods for a send, hunt plus 11 periods for a receive. Any request made while busy is ignored.
- R4: During a receive the data driver is off. tw_dat_i is sampled at the last cycle of each period. The hunt ends on the first low sample, or after HUNT_MAX high samples, and 11 tail periods follow in either case.
- R5: rx_valid is a one-cycle pulse in the first cycle after the receive completes, in which busy is already low. rx_byte holds the 8 tail samples, the first sample in bit 0.
- R6: rx_err is 1 when the parity sample differs from the XOR of the data samples or when either stop sample is 0. All 11 tail periods are clocked even when an error occurs.
- R7: Enable first drives data 0 and clock 1 for SETTLE_CYC cycles, then data 1 and clock 1 for SETTLE_CYC cycles, then PRE_PULSES clock periods with data 1. Afterwards the idle lines are driven with data 1 and clock 1.
- R8: Target reset drives the clock high for LEAD_CYC cycles and then low for LOW_CYC cycles, after which the clock returns high and busy falls.
- R9: A release request in idle makes the idle lines data 0 and clock 1, with both drivers on.
- R10: After reset, both drivers are off, tw_clk_o=1, tw_dat_o=0, busy=0, rx_valid=0 and rx_err=0.
- R11: When several requests arrive in the same idle cycle, only one is taken: target reset first, then enable, then send, then receive, then release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| send_req | input | 1 | Start sending send_byte |
| send_byte | input | 8 | Byte to send |
| recv_req | input | 1 | Start receiving a character |
| enable_req | input | 1 | Run the link-enable preamble |
| reset_req | input | 1 | Run the target reset pulse |
| release_req | input | 1 | Idle lines to data low, clock high |
| tw_dat_i | input | 1 | Data line as seen at the pad |
| tw_clk_o | output | 1 | Clock line value |
| tw_clk_oe | output | 1 | Clock line driver enable |
| tw_dat_o | output | 1 | Data line value |
| tw_dat_oe | output | 1 | Data line driver enable |
| busy | output | 1 | A sequence is in progress |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_byte and rx_err |
| rx_err | output | 1 | Last received character failed parity or stop check |

## Verification
The bench builds the block with HALF_DIV=2, HUNT_MAX=8, PRE_PULSES=16, SETTLE_CYC=3, LEAD_CYC=20 and LOW_CYC=5. A 4-cycle bit period keeps each frame short enough to sweep all 256 byte values as sends and as receives. With a hunt bound of eight, every start-bit position inside the bound can be reached, as can the hunt timeout. The short enable and reset windows let every cycle of those sequences be compared against values the bench works out arithmetically.

// File: rtl/twl_pkg.sv
package twl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TX,
    ST_HUNT,
    ST_RXBIT,
    ST_EN_LOW,
    ST_EN_SET,
    ST_EN_PULSE,
    ST_RST_LEAD,
    ST_RST_LOW
  } twl_state_e;

  localparam int FRAME_BITS   = 12;
  localparam int RX_TAIL_BITS = 11;

  // Character image, bit 0 leaves first: start, data LSB first, parity, two stops.
  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [7:0] b);
    return {2'b11, ^b, b, 1'b0};
  endfunction

endpackage

// File: rtl/twl_bit_timer.sv
module twl_bit_timer #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic clk_level,
  output logic period_end
);
  localparam int PERIOD = 2 * HALF_DIV;
  localparam int PW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [PW-1:0] ph_q, ph_d;

  assign period_end = run && (ph_q == PW'(PERIOD - 1));
  assign clk_level  = (ph_q >= PW'(HALF_DIV));

  always_comb begin
    ph_d = ph_q;
    if (!run || period_end) ph_d = '0;
    else                    ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/twl_wait_timer.sv
module twl_wait_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign done = (cnt_q == limit - 1'b1);

  always_comb begin
    if (restart) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/twl_rx_collect.sv
module twl_rx_collect #(
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sample,
  input  logic          last,
  input  logic [IW-1:0] idx,
  input  logic          bit_in,
  output logic [7:0]    byte_o,
  output logic          err_o,
  output logic          valid_o
);
  logic [7:0] sh_q, sh_d;
  logic       bad_q, bad_d;
  logic [7:0] out_q, out_d;
  logic       oerr_q, oerr_d;
  logic       val_q, val_d;

  always_comb begin
    sh_d   = sh_q;
    bad_d  = bad_q;
    out_d  = out_q;
    oerr_d = oerr_q;
    val_d  = 1'b0;
    if (start) begin
      sh_d  = '0;
      bad_d = 1'b0;
    end else if (sample) begin
      if (idx < IW'(8))       sh_d  = {bit_in, sh_q[7:1]};
      else if (idx == IW'(8)) bad_d = bad_q | (bit_in ^ (^sh_q));
      else                    bad_d = bad_q | ~bit_in;
      if (last) begin
        out_d  = sh_q;
        oerr_d = bad_d;
        val_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bad_q  <= 1'b0;
      out_q  <= '0;
      oerr_q <= 1'b0;
      val_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      bad_q  <= bad_d;
      out_q  <= out_d;
      oerr_q <= oerr_d;
      val_q  <= val_d;
    end
  end

  assign byte_o  = out_q;
  assign err_o   = oerr_q;
  assign valid_o = val_q;
endmodule

// File: rtl/twl_master.sv
module twl_master #(
  parameter int HALF_DIV   = 4,
  parameter int HUNT_MAX   = 256,
  parameter int PRE_PULSES = 16,
  parameter int SETTLE_CYC = 8,
  parameter int LEAD_CYC   = 2000,
  parameter int LOW_CYC    = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       send_req,
  input  logic [7:0] send_byte,
  input  logic       recv_req,
  input  logic       enable_req,
  input  logic       reset_req,
  input  logic       release_req,
  input  logic       tw_dat_i,
  output logic       tw_clk_o,
  output logic       tw_clk_oe,
  output logic       tw_dat_o,
  output logic       tw_dat_oe,
  output logic       busy,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       rx_err
);
  import twl_pkg::*;

  localparam int IDX_MAX   = (PRE_PULSES > FRAME_BITS) ? PRE_PULSES : FRAME_BITS;
  localparam int IW        = $clog2(IDX_MAX);
  localparam int HW        = (HUNT_MAX > 2) ? $clog2(HUNT_MAX) : 1;
  localparam int WAIT_MAX0 = (LEAD_CYC > LOW_CYC) ? LEAD_CYC : LOW_CYC;
  localparam int WAIT_MAX  = (WAIT_MAX0 > SETTLE_CYC) ? WAIT_MAX0 : SETTLE_CYC;
  localparam int CW        = $clog2(WAIT_MAX + 1);

  twl_state_e            state_q, state_d;
  logic [IW-1:0]         idx_q, idx_d;
  logic [HW-1:0]         hunt_q, hunt_d;
  logic [FRAME_BITS-1:0] frame_q, frame_d;
  logic                  link_q, link_d;
  logic                  idle_hi_q, idle_hi_d;

  logic          run, clk_level, period_end;
  logic [CW-1:0] wait_limit;
  logic          wait_done;
  logic          rx_start, rx_sample, rx_last;

  // Bit-period clocking shared by send, receive and the enable pulse train.
  assign run = (state_q == ST_TX) || (state_q == ST_HUNT) ||
               (state_q == ST_RXBIT) || (state_q == ST_EN_PULSE);

  twl_bit_timer #(.HALF_DIV(HALF_DIV)) u_bit (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .clk_level  (clk_level),
    .period_end (period_end)
  );

  always_comb begin
    case (state_q)
      ST_RST_LEAD: wait_limit = CW'(LEAD_CYC);
      ST_RST_LOW:  wait_limit = CW'(LOW_CYC);
      default:     wait_limit = CW'(SETTLE_CYC);
    endcase
  end

  twl_wait_timer #(.CW(CW)) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (state_d != state_q),
    .limit   (wait_limit),
    .done    (wait_done)
  );

  assign rx_start  = (state_q == ST_IDLE) && (state_d == ST_HUNT);
  assign rx_sample = (state_q == ST_RXBIT) && period_end;
  assign rx_last   = rx_sample && (idx_q == IW'(RX_TAIL_BITS - 1));

  twl_rx_collect #(.IW(IW)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (rx_start),
    .sample  (rx_sample),
    .last    (rx_last),
    .idx     (idx_q),
    .bit_in  (tw_dat_i),
    .byte_o  (rx_byte),
    .err_o   (rx_err),
    .valid_o (rx_valid)
  );

  // Sequencer next state.
  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    hunt_d    = hunt_q;
    frame_d   = frame_q;
    link_d    = link_q;
    idle_hi_d = idle_hi_q;
    case (state_q)
      ST_IDLE: begin
        if (reset_req) begin
          state_d = ST_RST_LEAD;
        end else if (enable_req) begin
          state_d = ST_EN_LOW;
        end else if (send_req) begin
          state_d = ST_TX;
          frame_d = build_frame(send_byte);
          idx_d   = '0;
        end else if (recv_req) begin
          state_d = ST_HUNT;
          hunt_d  = '0;
        end else if (release_req) begin
          idle_hi_d = 1'b0;
          link_d    = 1'b1;
        end
      end
      ST_TX: begin
        if (period_end) begin
          if (idx_q == IW'(FRAME_BITS - 1)) state_d = ST_IDLE;
          else                              idx_d   = idx_q + 1'b1;
        end
      end
      ST_HUNT: begin
        if (period_end) begin
          if (!tw_dat_i || (hunt_q == HW'(HUNT_MAX - 1))) begin
            state_d = ST_RXBIT;
            idx_d   = '0;
          end else begin
            hunt_d = hunt_q + 1'b1;
          end
        end
      end
      ST_RXBIT: begin
        if (period_end) begin
          if (idx_q == IW'(RX_TAIL_BITS - 1)) state_d = ST_IDLE;
          else                                idx_d   = idx_q + 1'b1;
        end
      end
      ST_EN_LOW: begin
        if (wait_done) state_d = ST_EN_SET;
      end
      ST_EN_SET: begin
        if (wait_done) begin
          state_d = ST_EN_PULSE;
          idx_d   = '0;
        end
      end
      ST_EN_PULSE: begin
        if (period_end) begin
          if (idx_q == IW'(PRE_PULSES - 1)) begin
            state_d   = ST_IDLE;
            link_d    = 1'b1;
            idle_hi_d = 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_RST_LEAD: begin
        if (wait_done) state_d = ST_RST_LOW;
      end
      ST_RST_LOW: begin
        if (wait_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      hunt_q    <= '0;
      frame_q   <= '0;
      link_q    <= 1'b0;
      idle_hi_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      idx_q     <= idx_d;
      hunt_q    <= hunt_d;
      frame_q   <= frame_d;
      link_q    <= link_d;
      idle_hi_q <= idle_hi_d;
    end
  end

  // Line drive per state.
  always_comb begin
    tw_clk_o  = 1'b1;
    tw_clk_oe = link_q;
    tw_dat_o  = idle_hi_q;
    tw_dat_oe = link_q;
    case (state_q)
      ST_TX: begin
        tw_clk_o  = clk_level;
        tw_clk_oe = 1'b1;
        tw_dat_o  = frame_q[idx_q];
        tw_dat_oe = 1'b1;
      end
      ST_HUNT, ST_RXBIT: begin
        tw_clk_o  = clk_level;
        tw_clk_oe = 1'b1;
        tw_dat_o  = 1'b0;
        tw_dat_oe = 1'b0;
      end
      ST_EN_LOW: begin
        tw_clk_oe = 1'b1;
        tw_dat_o  = 1'b0;
        tw_dat_oe = 1'b1;
      end
      ST_EN_SET: begin
        tw_clk_oe = 1'b1;
        tw_dat_o  = 1'b1;
        tw_dat_oe = 1'b1;
      end
      ST_EN_PULSE: begin
        tw_clk_o  = clk_level;
        tw_clk_oe = 1'b1;
        tw_dat_o  = 1'b1;
        tw_dat_oe = 1'b1;
      end
      ST_RST_LEAD: tw_clk_oe = 1'b1;
      ST_RST_LOW: begin
        tw_clk_o  = 1'b0;
        tw_clk_oe = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/twl_master_chk.sv
module twl_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic rx_valid,
  input logic tw_clk_o,
  input logic tw_clk_oe,
  input logic tw_dat_oe
);
  // R5: the receive strobe lasts a single cycle
  assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R5: the strobe appears exactly as the receive leaves busy
  assert_valid_at_busy_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (!busy && $past(busy)));

  // R2: the clock line is only ever pulled low while driven
  assert_low_clk_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tw_clk_o |-> tw_clk_oe);

  // R4: with the data line released the master still owns the clock
  assert_rx_clk_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tw_dat_oe) |-> tw_clk_oe);

  // R9: outside any sequence the clock rests high
  assert_idle_clk_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tw_clk_o);
endmodule

bind twl_master twl_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .rx_valid  (rx_valid),
  .tw_clk_o  (tw_clk_o),
  .tw_clk_oe (tw_clk_oe),
  .tw_dat_oe (tw_dat_oe)
);

// File: tb/sim_twl_master.sv
module sim_twl_master;
  localparam int CLK_PERIOD = 10;
  localparam int H    = 2;
  localparam int P    = 2 * H;
  localparam int HUNT = 8;
  localparam int PRE  = 16;
  localparam int SET  = 3;
  localparam int LEAD = 20;
  localparam int LOW  = 5;

  logic       clk, rst_n;
  logic       send_req, recv_req, enable_req, reset_req, release_req;
  logic [7:0] send_byte;
  logic       tw_dat_i;
  logic       tw_clk_o, tw_clk_oe, tw_dat_o, tw_dat_oe;
  logic       busy, rx_valid, rx_err;
  logic [7:0] rx_byte;

  int tests, fails;

  twl_master #(
    .HALF_DIV(H), .HUNT_MAX(HUNT), .PRE_PULSES(PRE),
    .SETTLE_CYC(SET), .LEAD_CYC(LEAD), .LOW_CYC(LOW)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .send_req(send_req), .send_byte(send_byte), .recv_req(recv_req),
    .enable_req(enable_req), .reset_req(reset_req), .release_req(release_req),
    .tw_dat_i(tw_dat_i),
    .tw_clk_o(tw_clk_o), .tw_clk_oe(tw_clk_oe),
    .tw_dat_o(tw_dat_o), .tw_dat_oe(tw_dat_oe),
    .busy(busy), .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_err(rx_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset_pulse(input bit extra);
    int bad;
    bad = 0;
    reset_req = 1'b1;
    if (extra) begin enable_req = 1'b1; send_req = 1'b1; send_byte = 8'h00; end
    @(negedge clk);
    reset_req = 1'b0; enable_req = 1'b0; send_req = 1'b0;
    for (int i = 0; i < LEAD; i++) begin
      if (tw_clk_o !== 1'b1 || tw_clk_oe !== 1'b1 || busy !== 1'b1) bad++;
      @(negedge clk);
    end
    for (int i = 0; i < LOW; i++) begin
      if (tw_clk_o !== 1'b0 || tw_clk_oe !== 1'b1 || busy !== 1'b1) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R8", "reset pulse shape mismatches", bad, 0);
    chk(tw_clk_o === 1'b1 && busy === 1'b0, "R8", "clock high, idle after pulse",
        {tw_clk_o, busy}, 2'b10);
    if (extra) chk(bad == 0, "R11", "reset wins over enable and send", bad, 0);
  endtask

  task automatic do_enable(input bit extra);
    int bad;
    bad = 0;
    enable_req = 1'b1;
    if (extra) begin send_req = 1'b1; recv_req = 1'b1; release_req = 1'b1; end
    @(negedge clk);
    enable_req = 1'b0; send_req = 1'b0; recv_req = 1'b0; release_req = 1'b0;
    for (int i = 0; i < SET; i++) begin
      if (tw_clk_o !== 1'b1 || tw_dat_o !== 1'b0 || tw_clk_oe !== 1'b1 ||
          tw_dat_oe !== 1'b1 || busy !== 1'b1) bad++;
      @(negedge clk);
    end
    for (int i = 0; i < SET; i++) begin
      if (tw_clk_o !== 1'b1 || tw_dat_o !== 1'b1 || tw_dat_oe !== 1'b1 || busy !== 1'b1) bad++;
      @(negedge clk);
    end
    for (int j = 0; j < PRE; j++) begin
      for (int m = 0; m < P; m++) begin
        if (tw_clk_o !== (m >= H) || tw_dat_o !== 1'b1 || tw_dat_oe !== 1'b1 ||
            busy !== 1'b1) bad++;
        @(negedge clk);
      end
    end
    chk(bad == 0, "R7", "enable preamble mismatches", bad, 0);
    chk(busy === 1'b0 && tw_dat_o === 1'b1 && tw_clk_o === 1'b1 &&
        tw_dat_oe === 1'b1 && tw_clk_oe === 1'b1, "R7", "idle after enable",
        {busy, tw_dat_o, tw_clk_o, tw_dat_oe, tw_clk_oe}, 5'b01111);
    if (extra) chk(bad == 0, "R11", "enable wins over send, receive, release", bad, 0);
  endtask

  task automatic do_tx(input logic [7:0] b, input bit poke);
    int bad_dat, bad_clk, bad_busy;
    logic [11:0] fr;
    bad_dat = 0; bad_clk = 0; bad_busy = 0;
    fr = {2'b11, ^b, b, 1'b0};
    send_byte = b; send_req = 1'b1;
    @(negedge clk);
    send_req = 1'b0;
    for (int j = 0; j < 12; j++) begin
      for (int m = 0; m < P; m++) begin
        if (poke && j == 5 && m == 1) begin
          send_req = 1'b1; send_byte = ~b; recv_req = 1'b1;
        end else begin
          send_req = 1'b0; recv_req = 1'b0;
        end
        if (tw_dat_o !== fr[j] || tw_dat_oe !== 1'b1) bad_dat++;
        if (tw_clk_o !== (m >= H) || tw_clk_oe !== 1'b1) bad_clk++;
        if (busy !== 1'b1) bad_busy++;
        @(negedge clk);
      end
    end
    send_req = 1'b0; recv_req = 1'b0;
    chk(bad_dat == 0, "R1", $sformatf("frame bits for byte %02h", b), bad_dat, 0);
    chk(bad_clk == 0, "R2", $sformatf("clock shape for byte %02h", b), bad_clk, 0);
    chk(bad_busy == 0 && busy === 1'b0, "R3", "busy window of a send",
        {bad_busy[7:0], busy}, 0);
    if (poke) begin
      @(negedge clk);
      chk(busy === 1'b0, "R3", "request during send was ignored", busy, 0);
    end
  endtask

  task automatic do_rx(input logic [7:0] b, input int k, input bit tmo,
                       input bit fp, input bit s1, input bit s2);
    int nh, bad_line, bad_busy;
    bit exp_err;
    logic [10:0] tail;
    bad_line = 0; bad_busy = 0;
    nh = tmo ? HUNT : k;
    tail = {s2, s1, (^b) ^ fp, b};
    exp_err = fp | ~s1 | ~s2;
    recv_req = 1'b1;
    @(negedge clk);
    recv_req = 1'b0;
    for (int j = 0; j < nh + 11; j++) begin
      if (j < nh) tw_dat_i = (!tmo && j == k - 1) ? 1'b0 : 1'b1;
      else        tw_dat_i = tail[j - nh];
      for (int m = 0; m < P; m++) begin
        if (tw_dat_oe !== 1'b0 || tw_clk_o !== (m >= H) || tw_clk_oe !== 1'b1) bad_line++;
        if (busy !== 1'b1) bad_busy++;
        @(negedge clk);
      end
    end
    tw_dat_i = 1'b1;
    chk(bad_line == 0, "R4", $sformatf("released line and clocking, byte %02h", b), bad_line, 0);
    chk(bad_busy == 0 && busy === 1'b0, "R3", "busy window of a receive",
        {bad_busy[7:0], busy}, 0);
    chk(rx_valid === 1'b1, "R5", "strobe after receive", rx_valid, 1);
    chk(rx_byte === b, "R5", "received byte", rx_byte, b);
    chk(rx_err === exp_err, "R6", $sformatf("error flag fp=%0d s1=%0d s2=%0d", fp, s1, s2),
        rx_err, exp_err);
    @(negedge clk);
    chk(rx_valid === 1'b0, "R5", "strobe lasts one cycle", rx_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL R3 watchdog: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0;
    rst_n = 1'b0;
    send_req = 1'b0; recv_req = 1'b0; enable_req = 1'b0;
    reset_req = 1'b0; release_req = 1'b0;
    send_byte = 8'h00; tw_dat_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(tw_clk_oe === 1'b0 && tw_dat_oe === 1'b0 && tw_clk_o === 1'b1 && tw_dat_o === 1'b0,
        "R10", "lines in reset", {tw_clk_oe, tw_dat_oe, tw_clk_o, tw_dat_o}, 4'b0010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && rx_valid === 1'b0 && rx_err === 1'b0, "R10", "flags after reset",
        {busy, rx_valid, rx_err}, 0);

    do_reset_pulse(1'b1);
    do_enable(1'b0);

    release_req = 1'b1;
    @(negedge clk);
    release_req = 1'b0;
    chk(tw_dat_o === 1'b0 && tw_dat_oe === 1'b1 && tw_clk_o === 1'b1 && tw_clk_oe === 1'b1 &&
        busy === 1'b0, "R9", "released idle lines",
        {tw_dat_o, tw_dat_oe, tw_clk_o, tw_clk_oe, busy}, 5'b01110);

    do_enable(1'b1);

    for (int v = 0; v < 256; v++) do_tx(v[7:0], 1'b0);
    do_tx(8'hA5, 1'b1);
    do_tx(8'h3C, 1'b1);

    for (int v = 0; v < 256; v++) do_rx(v[7:0], (v % HUNT) + 1, 1'b0, 1'b0, 1'b1, 1'b1);
    do_rx(8'h5A, 2, 1'b0, 1'b1, 1'b1, 1'b1);
    do_rx(8'h81, 1, 1'b0, 1'b0, 1'b0, 1'b1);
    do_rx(8'h7E, 3, 1'b0, 1'b0, 1'b1, 1'b0);
    do_rx(8'hFF, 4, 1'b0, 1'b1, 1'b0, 1'b0);
    do_rx(8'h00, 1, 1'b0, 1'b1, 1'b0, 1'b1);
    do_rx(8'hC3, 0, 1'b1, 1'b0, 1'b1, 1'b1);
    do_rx(8'h96, 0, 1'b1, 1'b1, 1'b1, 1'b1);

    do_reset_pulse(1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule